// File: doc/BRIEF.md
# Single-Bank DDR Write Sequencer with Automatic Precharge

This block sits on the controller side of a DDR SDRAM interface and carries out one complete write transaction on a single bank. The client offers a request with a valid/ready handshake: bank, row, column, four data words and four mask bits. The block then opens the row with ACTIVE. After the row-to-column delay it issues WRITE with address bit 10 set, so that the device closes the row by itself once the write is done. It then drives a burst of four data elements and the data strobe. It presents these to a double-rate output stage as two values per clock: phase 0 for the first half of the period and phase 1 for the second half.

Once the burst is out, the block keeps the bank marked busy. The busy time covers two limits: write recovery after the last data element, and the minimum time a row must stay open. It then adds the precharge period on top. Only after that does it accept another request. Every timing limit is an integer parameter counted in clock cycles. Command slots that carry no ACTIVE or WRITE hold a NOP.

Top module: `ddr_wap_seq`

## Requirements
- R1: While reset is asserted and right after it, `cmd` is NOP (4'b0111), `addr` and `ba` are zero, `bank_busy` is 0, `req_ready` is 1, `dq_en` is 0 and `dqs_en` is 2'b00. Asserting reset in the middle of a transaction returns all of these to idle at once.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. In the following cycle, `cmd` is ACTIVE (4'b0011, bits cs_n,ras_n,cas_n,we_n), `addr` equals the row, `ba` equals the bank, and `bank_busy` is high.
- R3: WRITE (4'b0100) comes exactly TRCD cycles after ACTIVE. Its `addr[COL_W-1:0]` carries the column, `addr[10]` is 1 to request automatic precharge, every other address bit is 0, and `ba` carries the accepted bank.
- R4: `dq_en` is high in the two cycles after WRITE and low otherwise. Data word i is `req_data[i*DQ_W +: DQ_W]`. Words 0 and 1 appear on `dq_ph0`/`dq_ph1` in the first of these cycles, and words 2 and 3 in the second. Both phases read zero while `dq_en` is low.
- R5: `dm_ph0`/`dm_ph1` carry `req_mask` bits in the same order as the data words, and a 1 marks that element as not to be written. Both read zero outside the burst.
- R6: In the WRITE cycle, the strobe is enabled in phase 1 only (`dqs_en`=2'b10, bit 0 is phase 0) and driven low (`dqs_lvl`=2'b00). This is the preamble.
- R7: In both data cycles, `dqs_en`=2'b11 and `dqs_lvl`=2'b01: high in phase 0 and low in phase 1. The first rising strobe edge therefore falls one clock after WRITE.
- R8: In the cycle after the last data, `dqs_en`=2'b01 with `dqs_lvl`=2'b00. This is the postamble. In all other cycles `dqs_en` is 2'b00.
- R9: `bank_busy` stays high for exactly T_END = max(TRCD+3+TWR, TRAS)+TRP cycles, starting with the ACTIVE cycle. `req_ready` is its inverse.
- R10: A request held on `req_valid` while the bank is busy produces no command. It is accepted at the first ready cycle, and its ACTIVE follows one cycle later, T_END+1 cycles after the previous ACTIVE.
- R11: Every cycle that is neither the ACTIVE cycle nor the WRITE cycle of a transaction shows NOP with `addr` and `ba` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Starting column |
| req_data | input | 4*DQ_W | Four data words, word 0 in the low bits |
| req_mask | input | 4 | Per-word mask, 1 = do not write |
| bank_busy | output | 1 | Bank occupied from ACTIVE until the precharge period ends |
| cmd | output | 4 | Command {cs_n,ras_n,cas_n,we_n} |
| addr | output | ROW_W | Address bus |
| ba | output | BANK_W | Bank address |
| dq_en | output | 1 | Data bus driven this cycle |
| dq_ph0 | output | DQ_W | Data, first half of the cycle |
| dq_ph1 | output | DQ_W | Data, second half of the cycle |
| dm_ph0 | output | 1 | Mask, first half of the cycle |
| dm_ph1 | output | 1 | Mask, second half of the cycle |
| dqs_en | output | 2 | Strobe driver enable per phase (bit 0 = first half) |
| dqs_lvl | output | 2 | Strobe level per phase (bit 0 = first half) |

## Verification
The bench places WRITE exactly at the row-to-column limit. A sequencer that counted from the acceptance edge instead of from ACTIVE would show WRITE one cycle early or late. It checks that the preamble occupies only the second half of the WRITE cycle and that the postamble occupies only the first half of the cycle after the data. A strobe shaper off by one phase would leave the first rising edge unpreceded by a low level, or would cut the last data element short. It holds a second request on `req_valid` across the whole busy window. A design that ignored busy would issue an overlapping ACTIVE, and one that dropped write recovery or the row-open minimum would release the bank several cycles too early. A reset applied in the middle of the burst confirms that the strobe and data drivers shut off immediately rather than finishing the burst.

// File: rtl/ddr_wap_pkg.sv
package ddr_wap_pkg;

  // Command encoding on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP   = 4'b0111,
    CMD_ACT   = 4'b0011,
    CMD_WRITE = 4'b0100
  } ddr_cmd_e;

  // Burst length is fixed by the transaction format
  localparam int unsigned BURST_LEN = 4;

  // Address bit that requests automatic precharge on WRITE
  localparam int unsigned AP_BIT = 10;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_wap_timeline.sv
// Tracks the age of the open transaction, counted from the ACTIVE cycle.
module ddr_wap_timeline #(
  parameter int unsigned T_END = 11,
  parameter int unsigned AGE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             accept,
  output logic             busy,
  output logic             active_nxt,
  output logic [AGE_W-1:0] age_nxt
);

  localparam logic [AGE_W-1:0] LAST_AGE = AGE_W'(T_END - 1);

  logic             active_q;
  logic [AGE_W-1:0] age_q;

  assign req_ready = !active_q;
  assign accept    = req_valid && !active_q;
  assign busy      = active_q;

  always_comb begin
    active_nxt = active_q;
    age_nxt    = age_q;
    if (accept) begin
      active_nxt = 1'b1;
      age_nxt    = '0;
    end else if (active_q) begin
      if (age_q == LAST_AGE) begin
        active_nxt = 1'b0;
        age_nxt    = '0;
      end else begin
        age_nxt = age_q + AGE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      age_q    <= '0;
    end else begin
      active_q <= active_nxt;
      age_q    <= age_nxt;
    end
  end

endmodule

// File: rtl/ddr_wap_cmd.sv
// Command and address bus: ACTIVE on acceptance, WRITE with auto precharge at age TRCD.
module ddr_wap_cmd
  import ddr_wap_pkg::*;
#(
  parameter int unsigned ROW_W  = 13,
  parameter int unsigned COL_W  = 10,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned AGE_W  = 4,
  parameter int unsigned TRCD   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              active_nxt,
  input  logic [AGE_W-1:0]  age_nxt,
  output logic [3:0]        cmd,
  output logic [ROW_W-1:0]  addr,
  output logic [BANK_W-1:0] ba
);

  localparam logic [AGE_W-1:0] WR_AGE = AGE_W'(TRCD);

  logic [COL_W-1:0]  col_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  wr_addr;
  ddr_cmd_e          cmd_d;
  logic [ROW_W-1:0]  addr_d;
  logic [BANK_W-1:0] ba_d;

  always_comb begin
    wr_addr              = '0;
    wr_addr[COL_W-1:0]   = col_q;
    wr_addr[AP_BIT]      = 1'b1;
  end

  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = '0;
    ba_d   = '0;
    if (accept) begin
      cmd_d  = CMD_ACT;
      addr_d = req_row;
      ba_d   = req_bank;
    end else if (active_nxt && (age_nxt == WR_AGE)) begin
      cmd_d  = CMD_WRITE;
      addr_d = wr_addr;
      ba_d   = bank_q;
    end
  end

  // Request fields needed later, clock-enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      bank_q <= '0;
    end else if (accept) begin
      col_q  <= req_col;
      bank_q <= req_bank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd  <= CMD_NOP;
      addr <= '0;
      ba   <= '0;
    end else begin
      cmd  <= cmd_d;
      addr <= addr_d;
      ba   <= ba_d;
    end
  end

endmodule

// File: rtl/ddr_wap_burst.sv
// Data, mask and strobe shaping, two phases per clock.
module ddr_wap_burst
  import ddr_wap_pkg::*;
#(
  parameter int unsigned DQ_W  = 8,
  parameter int unsigned AGE_W = 4,
  parameter int unsigned TRCD  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      accept,
  input  logic [BURST_LEN*DQ_W-1:0] req_data,
  input  logic [BURST_LEN-1:0]      req_mask,
  input  logic                      active_nxt,
  input  logic [AGE_W-1:0]          age_nxt,
  output logic                      dq_en,
  output logic [DQ_W-1:0]           dq_ph0,
  output logic [DQ_W-1:0]           dq_ph1,
  output logic                      dm_ph0,
  output logic                      dm_ph1,
  output logic [1:0]                dqs_en,
  output logic [1:0]                dqs_lvl
);

  localparam logic [AGE_W-1:0] PRE_AGE   = AGE_W'(TRCD);
  localparam logic [AGE_W-1:0] PAIR0_AGE = AGE_W'(TRCD + 1);
  localparam logic [AGE_W-1:0] PAIR1_AGE = AGE_W'(TRCD + 2);
  localparam logic [AGE_W-1:0] POST_AGE  = AGE_W'(TRCD + 3);
  localparam int unsigned      PAIRS     = BURST_LEN / 2;

  logic [BURST_LEN*DQ_W-1:0] data_q;
  logic [BURST_LEN-1:0]      mask_q;
  logic [DQ_W-1:0]           even_w [PAIRS];
  logic [DQ_W-1:0]           odd_w  [PAIRS];

  logic            dq_en_d;
  logic [DQ_W-1:0] ph0_d;
  logic [DQ_W-1:0] ph1_d;
  logic            dm0_d;
  logic            dm1_d;
  logic [1:0]      dqs_en_d;
  logic [1:0]      dqs_lvl_d;

  generate
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      assign even_w[p] = data_q[(2*p)*DQ_W +: DQ_W];
      assign odd_w[p]  = data_q[(2*p+1)*DQ_W +: DQ_W];
    end
  endgenerate

  always_comb begin
    dq_en_d   = 1'b0;
    ph0_d     = '0;
    ph1_d     = '0;
    dm0_d     = 1'b0;
    dm1_d     = 1'b0;
    dqs_en_d  = 2'b00;
    dqs_lvl_d = 2'b00;
    if (active_nxt) begin
      if (age_nxt == PRE_AGE) begin
        dqs_en_d = 2'b10;
      end else if (age_nxt == PAIR0_AGE) begin
        dq_en_d   = 1'b1;
        ph0_d     = even_w[0];
        ph1_d     = odd_w[0];
        dm0_d     = mask_q[0];
        dm1_d     = mask_q[1];
        dqs_en_d  = 2'b11;
        dqs_lvl_d = 2'b01;
      end else if (age_nxt == PAIR1_AGE) begin
        dq_en_d   = 1'b1;
        ph0_d     = even_w[1];
        ph1_d     = odd_w[1];
        dm0_d     = mask_q[2];
        dm1_d     = mask_q[3];
        dqs_en_d  = 2'b11;
        dqs_lvl_d = 2'b01;
      end else if (age_nxt == POST_AGE) begin
        dqs_en_d = 2'b01;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      mask_q <= '0;
    end else if (accept) begin
      data_q <= req_data;
      mask_q <= req_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_en   <= 1'b0;
      dq_ph0  <= '0;
      dq_ph1  <= '0;
      dm_ph0  <= 1'b0;
      dm_ph1  <= 1'b0;
      dqs_en  <= 2'b00;
      dqs_lvl <= 2'b00;
    end else begin
      dq_en   <= dq_en_d;
      dq_ph0  <= ph0_d;
      dq_ph1  <= ph1_d;
      dm_ph0  <= dm0_d;
      dm_ph1  <= dm1_d;
      dqs_en  <= dqs_en_d;
      dqs_lvl <= dqs_lvl_d;
    end
  end

endmodule

// File: rtl/ddr_wap_seq.sv
// Top: single-bank write with automatic precharge.
module ddr_wap_seq
  import ddr_wap_pkg::*;
#(
  parameter int unsigned ROW_W  = 13,
  parameter int unsigned COL_W  = 10,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned DQ_W   = 8,
  parameter int unsigned TRCD   = 3,
  parameter int unsigned TWR    = 2,
  parameter int unsigned TRP    = 3,
  parameter int unsigned TRAS   = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [BANK_W-1:0]         req_bank,
  input  logic [ROW_W-1:0]          req_row,
  input  logic [COL_W-1:0]          req_col,
  input  logic [BURST_LEN*DQ_W-1:0] req_data,
  input  logic [BURST_LEN-1:0]      req_mask,
  output logic                      bank_busy,
  output logic [3:0]                cmd,
  output logic [ROW_W-1:0]          addr,
  output logic [BANK_W-1:0]         ba,
  output logic                      dq_en,
  output logic [DQ_W-1:0]           dq_ph0,
  output logic [DQ_W-1:0]           dq_ph1,
  output logic                      dm_ph0,
  output logic                      dm_ph1,
  output logic [1:0]                dqs_en,
  output logic [1:0]                dqs_lvl
);

  // Last data ends at age TRCD+3; recovery then runs TWR cycles.
  localparam int unsigned WR_DONE = TRCD + 3 + TWR;
  localparam int unsigned T_PRE   = max_u(WR_DONE, TRAS);
  localparam int unsigned T_END   = T_PRE + TRP;
  localparam int unsigned AGE_W   = $clog2(T_END + 1);

  logic             accept;
  logic             active_nxt;
  logic [AGE_W-1:0] age_nxt;

  ddr_wap_timeline #(
    .T_END (T_END),
    .AGE_W (AGE_W)
  ) u_timeline (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .accept     (accept),
    .busy       (bank_busy),
    .active_nxt (active_nxt),
    .age_nxt    (age_nxt)
  );

  ddr_wap_cmd #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .BANK_W (BANK_W),
    .AGE_W  (AGE_W),
    .TRCD   (TRCD)
  ) u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_bank   (req_bank),
    .req_row    (req_row),
    .req_col    (req_col),
    .active_nxt (active_nxt),
    .age_nxt    (age_nxt),
    .cmd        (cmd),
    .addr       (addr),
    .ba         (ba)
  );

  ddr_wap_burst #(
    .DQ_W  (DQ_W),
    .AGE_W (AGE_W),
    .TRCD  (TRCD)
  ) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_data   (req_data),
    .req_mask   (req_mask),
    .active_nxt (active_nxt),
    .age_nxt    (age_nxt),
    .dq_en      (dq_en),
    .dq_ph0     (dq_ph0),
    .dq_ph1     (dq_ph1),
    .dm_ph0     (dm_ph0),
    .dm_ph1     (dm_ph1),
    .dqs_en     (dqs_en),
    .dqs_lvl    (dqs_lvl)
  );

endmodule

// File: rtl/ddr_wap_seq_chk.sv
module ddr_wap_seq_chk
  import ddr_wap_pkg::*;
#(
  parameter int unsigned ROW_W = 13,
  parameter int unsigned TRCD  = 3,
  parameter int unsigned T_END = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             bank_busy,
  input logic [3:0]       cmd,
  input logic [ROW_W-1:0] addr,
  input logic             dq_en,
  input logic [1:0]       dqs_en,
  input logic [1:0]       dqs_lvl
);

  localparam int unsigned CW = $clog2(T_END + 2) + 1;
  localparam logic [CW-1:0] SAT = '1;

  logic [CW-1:0] since_act;
  logic          seen_act;

  // Cycles elapsed since the most recent ACTIVE, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= '0;
      seen_act  <= 1'b0;
    end else if (cmd == CMD_ACT) begin
      since_act <= CW'(1);
      seen_act  <= 1'b1;
    end else if (since_act != SAT) begin
      since_act <= since_act + CW'(1);
    end
  end

  p_accept_opens_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (bank_busy && cmd == CMD_ACT));

  p_write_after_rcd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WRITE) |-> (seen_act && since_act == CW'(TRCD)));

  p_write_autopre_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WRITE) |-> addr[AP_BIT]);

  p_preamble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_en) |-> ($past(dqs_en) == 2'b10 && $past(dqs_lvl) == 2'b00));

  p_strobe_with_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dq_en |-> (dqs_en == 2'b11 && dqs_lvl == 2'b01));

  p_postamble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_en) |-> (dqs_en == 2'b01 && dqs_lvl == 2'b00));

  p_act_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT && seen_act) |-> (since_act > CW'(T_END)));

  p_legal_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_NOP || cmd == CMD_ACT || cmd == CMD_WRITE));

endmodule

bind ddr_wap_seq ddr_wap_seq_chk #(
  .ROW_W (ROW_W),
  .TRCD  (TRCD),
  .T_END (T_END)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .bank_busy (bank_busy),
  .cmd       (cmd),
  .addr      (addr),
  .dq_en     (dq_en),
  .dqs_en    (dqs_en),
  .dqs_lvl   (dqs_lvl)
);

// File: tb/ddr_wap_seq_test.sv
`timescale 1ns/1ps
module ddr_wap_seq_test;

  localparam int ROW_W = 13;
  localparam int COL_W = 10;
  localparam int BANK_W = 2;
  localparam int DQ_W = 8;
  localparam int TRCD = 3;
  localparam int TWR = 2;
  localparam int TRP = 3;
  localparam int TRAS = 6;
  localparam int WR_DONE = TRCD + 3 + TWR;
  localparam int T_PRE = (WR_DONE > TRAS) ? WR_DONE : TRAS;
  localparam int T_END = T_PRE + TRP;

  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] ACT = 4'b0011;
  localparam logic [3:0] WRC = 4'b0100;

  // {bank[60:59], row[58:46], col[45:36], data[35:4], mask[3:0]}
  localparam int NV = 4;
  localparam logic [60:0] VEC [NV] = '{
    {2'd1, 13'h0abc, 10'h155, 32'h44332211, 4'b0000},
    {2'd3, 13'h1fff, 10'h3ff, 32'hdeadbeef, 4'b1010},
    {2'd0, 13'h0000, 10'h000, 32'h00ff00ff, 4'b0101},
    {2'd2, 13'h1234, 10'h2a1, 32'h87654321, 4'b1111}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic req_ready;
  logic [BANK_W-1:0] req_bank;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic [4*DQ_W-1:0] req_data;
  logic [3:0] req_mask;
  logic bank_busy;
  logic [3:0] cmd;
  logic [ROW_W-1:0] addr;
  logic [BANK_W-1:0] ba;
  logic dq_en;
  logic [DQ_W-1:0] dq_ph0, dq_ph1;
  logic dm_ph0, dm_ph1;
  logic [1:0] dqs_en, dqs_lvl;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ddr_wap_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_data(req_data), .req_mask(req_mask), .bank_busy(bank_busy),
    .cmd(cmd), .addr(addr), .ba(ba), .dq_en(dq_en), .dq_ph0(dq_ph0),
    .dq_ph1(dq_ph1), .dm_ph0(dm_ph0), .dm_ph1(dm_ph1),
    .dqs_en(dqs_en), .dqs_lvl(dqs_lvl)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_req(input logic [60:0] v);
    req_bank  = v[60:59];
    req_row   = v[58:46];
    req_col   = v[45:36];
    req_data  = v[35:4];
    req_mask  = v[3:0];
    req_valid = 1'b1;
  endtask

  task automatic check_idle(input string tag);
    chk({tag, " cmd"}, 64'(cmd), 64'(NOP));
    chk({tag, " addr"}, 64'(addr), 64'd0);
    chk({tag, " ba"}, 64'(ba), 64'd0);
    chk({tag, " busy"}, 64'(bank_busy), 64'd0);
    chk({tag, " ready"}, 64'(req_ready), 64'd1);
    chk({tag, " dq_en"}, 64'(dq_en), 64'd0);
    chk({tag, " dqs_en"}, 64'(dqs_en), 64'd0);
  endtask

  // Expected outputs at age k (k=0 is the ACTIVE cycle), sampled mid-cycle
  task automatic expect_cycle(input int k, input logic [60:0] v);
    logic [ROW_W-1:0] wa;
    logic [DQ_W-1:0] w [4];
    for (int i = 0; i < 4; i++) w[i] = v[4 + i*DQ_W +: DQ_W];
    wa = '0;
    wa[COL_W-1:0] = v[45:36];
    wa[10] = 1'b1;
    chk("R9 busy during transaction", 64'(bank_busy), 64'd1);
    chk("R9 ready low while busy", 64'(req_ready), 64'd0);
    if (k == 0) begin
      chk("R2 ACTIVE cmd", 64'(cmd), 64'(ACT));
      chk("R2 ACTIVE row", 64'(addr), 64'(v[58:46]));
      chk("R2 ACTIVE bank", 64'(ba), 64'(v[60:59]));
    end else if (k == TRCD) begin
      chk("R3 WRITE cmd", 64'(cmd), 64'(WRC));
      chk("R3 WRITE col+A10", 64'(addr), 64'(wa));
      chk("R3 WRITE bank", 64'(ba), 64'(v[60:59]));
    end else begin
      chk("R11 NOP cmd", 64'(cmd), 64'(NOP));
      chk("R11 NOP addr/ba", 64'({ba, addr}), 64'd0);
    end
    if (k == TRCD + 1 || k == TRCD + 2) begin
      int p = k - TRCD - 1;
      chk("R4 dq_en", 64'(dq_en), 64'd1);
      chk("R4 data phase0", 64'(dq_ph0), 64'(w[2*p]));
      chk("R4 data phase1", 64'(dq_ph1), 64'(w[2*p+1]));
      chk("R5 mask phases", 64'({dm_ph1, dm_ph0}), 64'({v[2*p+1], v[2*p]}));
      chk("R7 strobe toggle", 64'({dqs_en, dqs_lvl}), 64'({2'b11, 2'b01}));
    end else begin
      chk("R4 no data", 64'({dq_en, dq_ph0, dq_ph1}), 64'd0);
      chk("R5 no mask", 64'({dm_ph1, dm_ph0}), 64'd0);
      if (k == TRCD)
        chk("R6 preamble", 64'({dqs_en, dqs_lvl}), 64'({2'b10, 2'b00}));
      else if (k == TRCD + 3)
        chk("R8 postamble", 64'({dqs_en, dqs_lvl}), 64'({2'b01, 2'b00}));
      else
        chk("R8 strobe off", 64'({dqs_en, dqs_lvl}), 64'd0);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_bank = '0; req_row = '0; req_col = '0; req_data = '0; req_mask = '0;
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");

    // Table walk: one full transaction per vector
    for (int n = 0; n < NV; n++) begin
      drive_req(VEC[n]);
      chk("R2 ready before accept", 64'(req_ready), 64'd1);
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < T_END; k++) begin
        expect_cycle(k, VEC[n]);
        @(negedge clk);
      end
      check_idle("R9 released after T_END");
      @(negedge clk);
    end

    // Held-off request: B waits on valid during A's busy window
    drive_req(VEC[0]);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < T_END; k++) begin
      if (k == 2) drive_req(VEC[1]);
      expect_cycle(k, VEC[0]);
      @(negedge clk);
    end
    chk("R10 ready at first free cycle", 64'(req_ready), 64'd1);
    chk("R10 no command while held", 64'(cmd), 64'(NOP));
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 held request ACTIVE at T_END+1", 64'(cmd), 64'(ACT));
    for (int k = 0; k < T_END; k++) begin
      expect_cycle(k, VEC[1]);
      @(negedge clk);
    end
    check_idle("R10 after held request");

    // Reset in the middle of the burst
    drive_req(VEC[3]);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k <= TRCD + 1; k++) @(negedge clk);
    chk("R1 burst active before reset", 64'(dq_en), 64'd1);
    rst_n = 1'b0;
    #1;
    check_idle("R1 mid-burst reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after mid-burst reset");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule